// File: doc/BRIEF.md
# Signed Running Counter With Writeback

This block sweeps a fixed-length array of 16-bit two's-complement words held in an external single-port memory. On a start pulse it clears a running counter and an index, then for each word in ascending address order it issues a read, looks at the returned value, and moves the counter up by one when the word is strictly positive or down by one otherwise. Zero and negative words both count down. The updated counter is then stored over the word that was just read, so the array ends up holding the running tally at every position.

The decision for each word is taken by the controller itself. A test state inspects the read data and branches to one of two separate states, one that increments and one that decrements. There is no combinational select that merges the two paths. When the index reaches the array length, the block raises `done_o` and shows the final counter on `count_o`. Both stay put until the next start. Memory accesses are single-word and strictly sequential: one read, then one write, per element.

Top module: `sign_walk_top`

## Requirements
- R1: While reset is asserted and after reset until a start, `done_o`, `mem_rd_o` and `mem_wr_o` are 0 and `count_o` is 0.
- R2: A start accepted while idle or done clears the counter and index, and then reads exactly N (default 100) words at addresses base, base+1, ..., base+N-1 in that order.
- R3: A word whose bit 15 is 0 and that is nonzero raises the counter by exactly 1.
- R4: A word that is zero or has bit 15 set lowers the counter by exactly 1, wrapping modulo 2^16.
- R5: After each update, the new counter value is written to the address just read. `mem_wr_o` is high for exactly one cycle per element, and each element gets exactly one write.
- R6: The word is taken from `mem_rdata_i` one cycle after the cycle in which `mem_rd_o` is high. `mem_rd_o` and `mem_wr_o` are never high together.
- R7: After the last writeback, `done_o` rises and stays high, with `count_o` holding the final value and no memory strobe active, until the next start.
- R8: A start pulse that arrives while a sweep is in progress has no effect on that sweep's accesses or results.
- R9: Asserting `rst_ni` in the middle of a sweep returns the block to idle. A later start then runs a complete, correct sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep (accepted only when idle or done) |
| base_addr_i | input | AW | Address of the first array word; held stable during a sweep |
| mem_addr_o | output | AW | Memory word address |
| mem_rd_o | output | 1 | Read strobe; data is expected on the next cycle |
| mem_wr_o | output | 1 | Write strobe, one cycle |
| mem_rdata_i | input | DW | Read data from memory |
| mem_wdata_o | output | DW | Write data (updated counter) |
| count_o | output | DW | Running counter; the final value once done |
| done_o | output | 1 | Sweep complete, held until next start |

## Verification
The sweep is run on arrays that are all small positives, all zeros, all negatives, and alternating signs. A further array mixes the boundary words 0x0001, 0x7FFF, 0x8000 and 0xFFFF. Each of these exposes a different mistake: a wrong sign test, a wrong zero test, or a swapped branch. Each write is compared, address and data, against a tally computed independently, so a slip in write order or write address is caught at the first wrong write rather than only at the end. Separate runs pulse start in the middle of a sweep, pull reset in the middle of a sweep, and change the base address, to cover R8, R9 and R2.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BOUND, ST_READ, ST_TEST, ST_INC, ST_DEC, ST_WRITE, ST_NEXT, ST_FIN
  } sw_state_e;
endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic at_end_i,
  input  logic pos_i,
  output logic clr_o,
  output logic inc_o,
  output logic dec_o,
  output logic step_o,
  output logic rd_o,
  output logic wr_o,
  output logic done_o
);
  sw_state_e state_q, state_d;
  logic      idle_like;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_FIN: if (start_i) state_d = ST_BOUND;
      ST_BOUND:        state_d = at_end_i ? ST_FIN : ST_READ;
      ST_READ:         state_d = ST_TEST;
      ST_TEST:         state_d = pos_i ? ST_INC : ST_DEC;  // branch kept as states
      ST_INC, ST_DEC:  state_d = ST_WRITE;
      ST_WRITE:        state_d = ST_NEXT;
      ST_NEXT:         state_d = ST_BOUND;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign clr_o  = idle_like && start_i;
  assign inc_o  = (state_q == ST_INC);
  assign dec_o  = (state_q == ST_DEC);
  assign step_o = (state_q == ST_NEXT);
  assign rd_o   = (state_q == ST_READ);
  assign wr_o   = (state_q == ST_WRITE);
  assign done_o = (state_q == ST_FIN);
endmodule

// File: rtl/sw_index.sv
module sw_index #(
  parameter int AW = 12,
  parameter int N  = 100,
  localparam int IW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  assign addr_o   = base_i + AW'(idx_q);
  assign at_end_o = (idx_q == IW'(N));
endmodule

// File: rtl/sw_acc.sv
module sw_acc #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic [DW-1:0] rdata_i,
  output logic          pos_o,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] acc_q;

  // strictly positive: sign clear and not zero
  assign pos_o = !rdata_i[DW-1] && (|rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (inc_i)  acc_q <= acc_q + 1'b1;
    else if (dec_i)  acc_q <= acc_q - 1'b1;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/sign_walk_top.sv
module sign_walk_top #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int N  = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] count_o,
  output logic          done_o
);
  logic clr, inc, dec, step, at_end, pos;

  sw_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .at_end_i(at_end), .pos_i(pos),
    .clr_o(clr), .inc_o(inc), .dec_o(dec), .step_o(step),
    .rd_o(mem_rd_o), .wr_o(mem_wr_o), .done_o(done_o)
  );

  sw_index #(.AW(AW), .N(N)) u_index (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step),
    .base_i(base_addr_i), .addr_o(mem_addr_o), .at_end_o(at_end)
  );

  sw_acc #(.DW(DW)) u_acc (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(inc), .dec_i(dec),
    .rdata_i(mem_rdata_i), .pos_o(pos), .acc_o(count_o)
  );

  assign mem_wdata_o = count_o;
endmodule

// File: rtl/sign_walk_chk.sv
module sign_walk_chk #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int N  = 100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] base_addr_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [DW-1:0] count_o,
  input logic          done_o
);
  logic [AW-1:0] rd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_addr_q <= '0;
    else if (mem_rd_o) rd_addr_q <= mem_addr_o;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R6
  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o); // R5
  AST_WR_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o == rd_addr_q)); // R5
  AST_RD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> ((mem_addr_o - base_addr_i) < AW'(N))); // R2
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(count_o))); // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_rd_o && !mem_wr_o)); // R7
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(start_i) && !$stable(count_o)) |->
      ((count_o - $past(count_o)) == DW'(1) ||
       (count_o - $past(count_o)) == {DW{1'b1}})); // R3
endmodule

bind sign_walk_top sign_walk_chk #(.DW(DW), .AW(AW), .N(N)) u_chk (
  .clk_i, .rst_ni, .start_i, .base_addr_i, .mem_addr_o,
  .mem_rd_o, .mem_wr_o, .count_o, .done_o
);

// File: tb/tb_sign_walk_top.sv
module tb_sign_walk_top;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int N  = 100;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_wr_o, done_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [DW-1:0] mem_wdata_o, count_o;

  sign_walk_top #(.DW(DW), .AW(AW), .N(N)) dut (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] exp_mem [0:255];

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_item_t;
  wr_item_t sb_q[$];

  // memory model: data one cycle after read strobe
  always @(posedge clk_i) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: compare writes as they appear
  always @(negedge clk_i) begin
    if (rst_ni && mem_wr_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R5 extra write", {20'h0, mem_addr_o}, 32'h0);
      end else begin
        wr_item_t e;
        e = sb_q.pop_front();
        check(mem_addr_o == e.a, "R2/R5 write addr", {20'h0, mem_addr_o}, {20'h0, e.a});
        check(mem_wdata_o == e.d, "R3/R4 write data", {16'h0, mem_wdata_o}, {16'h0, e.d});
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int kind, input int i);
    case (kind)
      0: return DW'(i + 1);                         // all positive
      1: return '0;                                 // all zero
      2: return DW'(-(i + 1));                      // all negative
      3: return (i % 2 == 0) ? DW'(5) : DW'(-5);    // alternating
      default: case (i % 4)
        0: return 16'h0001;
        1: return 16'h7FFF;
        2: return 16'h8000;
        default: return 16'hFFFF;
      endcase
    endcase
  endfunction

  // driver: load array, push expected writes
  task automatic prep(input int kind, input int base, output logic [DW-1:0] fin);
    logic [DW-1:0] x = '0;
    for (int k = 0; k < 256; k++) begin mem[k] = 16'h1234; exp_mem[k] = 16'h1234; end
    sb_q.delete();
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] v = pat(kind, i);
      mem[base + i] = v;
      if (!v[DW-1] && v != 0) x = x + 1'b1; else x = x - 1'b1;
      exp_mem[base + i] = x;
      sb_q.push_back('{a: AW'(base + i), d: x});
    end
    fin = x;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic run_case(input int kind, input int base, input bit poke, input string tag);
    logic [DW-1:0] fin;
    prep(kind, base, fin);
    @(negedge clk_i); base_addr_i = AW'(base);
    pulse_start();
    if (poke) begin  // R8: start while busy
      repeat (37) @(negedge clk_i);
      start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
      repeat (200) @(negedge clk_i);
      start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    end
    wait_done();
    check(count_o == fin, {tag, " final count"}, {16'h0, count_o}, {16'h0, fin});
    check(sb_q.size() == 0, "R5 all writes seen", sb_q.size(), 0);
    for (int k = 0; k < 256; k++)
      if (mem[k] != exp_mem[k]) begin
        check(1'b0, "R5 memory image", {16'h0, mem[k]}, {16'h0, exp_mem[k]});
        break;
      end
    n_chk++;
    repeat (6) @(negedge clk_i);
    check(done_o && count_o == fin, "R7 done held", {15'h0, done_o, count_o}, {15'h0, 1'b1, fin});
    check(!mem_rd_o && !mem_wr_o, "R7 no strobe when done", {mem_rd_o, mem_wr_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!done_o && !mem_rd_o && !mem_wr_o && count_o == 0, "R1 in reset",
          {done_o, mem_rd_o, mem_wr_o, count_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(!done_o && !mem_rd_o && !mem_wr_o && count_o == 0, "R1 idle",
          {done_o, mem_rd_o, mem_wr_o, count_o}, 0);

    run_case(0, 10, 1'b0, "R3 all positive");
    run_case(1, 10, 1'b0, "R4 all zero");
    run_case(2, 40, 1'b0, "R4 all negative");
    run_case(3, 10, 1'b0, "R3/R4 alternating");
    run_case(4, 100, 1'b0, "R3/R4 boundary words");
    run_case(3, 5, 1'b1, "R8 start while busy");

    // R9: reset mid-sweep
    begin
      logic [DW-1:0] fin;
      prep(4, 20, fin);
      @(negedge clk_i); base_addr_i = AW'(20);
      pulse_start();
      repeat (150) @(negedge clk_i);
      rst_ni = 1'b0;
      @(negedge clk_i);
      sb_q.delete();
      check(!done_o && !mem_rd_o && !mem_wr_o && count_o == 0, "R9 reset mid-sweep",
            {done_o, mem_rd_o, mem_wr_o, count_o}, 0);
      rst_ni = 1'b1;
      repeat (5) @(negedge clk_i);
      check(!mem_rd_o && !mem_wr_o && !done_o, "R9 stays idle", {done_o, mem_rd_o, mem_wr_o}, 0);
    end
    run_case(0, 30, 1'b0, "R9 rerun after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule